// File: doc/BRIEF.md
# Packed Instruction Slot Sequencer

This block sits between the instruction fetch path and the execute stage of a small stack-machine core. Each fetched word is 18 bits wide and carries up to four short opcodes. The sequencer holds one word at a time. It presents the opcodes to the execute stage one after another, starting at the leftmost slot. It asks for a new word only after the held word has been used up, so a single fetch can feed up to four instructions.

Two opcodes change the flow inside a word. A no-op value ends the word at once. A loop opcode ("next") tests a small counter: while the counter is nonzero it sends issue back to the first slot of the same held word, with no fetch. This lets a tight loop, such as a block copy from a neighbour's port, run from one word. Words arrive on a valid/ready stream, from local memory or from an inter-core port register. While no word is offered, issue simply waits.

Back-pressure rules:
- On the input stream, `in_ready` is high exactly while no word is held. A word is taken on a clock edge where `in_valid` and `in_ready` are both high.
- On the output stream, an opcode is consumed on a clock edge where `out_valid` and `out_ready` are both high.
- While `out_ready` is low, the presented opcode and slot index stay unchanged.

Top module: `pkseq_issue`

## Requirements
- R1: A synchronous active-high reset empties the sequencer and clears the loop counter to zero. After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A word is accepted on an edge where `in_valid` and `in_ready` are both 1. In the next cycle `in_ready` is 0, and slot 0 of that word is presented with `out_slot` equal to 0.
- R3: The slot fields are: slot 0 is `in_word[17:13]`, slot 1 is `[12:8]`, slot 2 is `[7:3]`, and slot 3 is `[2:0]`. The 3-bit slot 3 field becomes the opcode `{field, 2'b00}`. `out_slot` reports the index of the presented slot.
- R4: Slots are issued in increasing order, one per accepted handshake. While `out_valid` is 1 and `out_ready` is 0, `out_op` and `out_slot` hold their values.
- R5: A consumed slot 3 that does not loop back ends the word. In the next cycle `in_ready` is 1 and `out_valid` is 0.
- R6: The no-op code `5'b11100` (slot 3 field `3'b111`) is never presented, in any slot. In the cycle it is reached, `out_valid` is 0 and the word is discarded. `in_ready` rises in the following cycle.
- R7: The loop code `5'b00100` (slot 3 field `3'b001`) tests the counter when it is consumed. If the counter is nonzero, the counter decrements and the next presented slot is slot 0 of the same word, with no fetch (`in_ready` stays 0).
- R8: A consumed loop code that finds the counter at zero behaves like any other opcode: issue goes to the next slot, or the word ends if it sat in slot 3.
- R9: A `cnt_load` of 1 at an edge writes `cnt_value` into the counter. The load takes priority over a decrement at the same edge. The loop decision at that edge uses the counter value held before the edge.
- R10: While no word is held and `in_valid` is 0, `out_valid` stays 0 and `in_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch stream: a word is offered |
| in_ready | output | 1 | Fetch stream: no word held, ready for a new one |
| in_word | input | 18 | Fetch stream: packed instruction word |
| out_valid | output | 1 | Issue stream: an opcode is presented |
| out_ready | input | 1 | Issue stream: execute stage takes the opcode |
| out_op | output | 5 | Presented opcode |
| out_slot | output | 2 | Slot index of the presented opcode |
| cnt_load | input | 1 | Load the loop counter |
| cnt_value | input | 8 | Value for the loop counter |

## Verification
A wrong slot pointer shows up in the same cycle as a mismatched `out_slot` and `out_op` pair. A wrong held-word flag shows up at once as a wrong `in_ready`. A wrong loop counter stays hidden until the next loop opcode is consumed. The error then shows one cycle later, as a loop-back where a fall-through was due or the reverse, so the bench pairs counter loads with loop opcodes. The bench models issue cycle by cycle and compares every output on every cycle, so any divergence is caught within one clock of its first visible effect.

// File: rtl/pkseq_pkg.sv
package pkseq_pkg;
  localparam int          OPW      = 5;
  localparam logic [4:0]  OPC_NOP  = 5'b11100;
  localparam logic [4:0]  OPC_NEXT = 5'b00100;
endpackage

// File: rtl/pkseq_slot_mux.sv
module pkseq_slot_mux #(
  parameter int WORD_W = 18,
  parameter int OP_W   = 5,
  parameter int NSLOT  = 4
) (
  input  logic [WORD_W-1:0]          word,
  input  logic [$clog2(NSLOT)-1:0]   slot,
  output logic [OP_W-1:0]            op
);
  localparam int LAST_W = WORD_W - (NSLOT-1)*OP_W;
  localparam int PAD_W  = OP_W - LAST_W;

  logic [OP_W-1:0] ops [NSLOT];

  // full-width slots taken from the top of the word downward
  for (genvar g = 0; g < NSLOT-1; g++) begin : g_full
    assign ops[g] = word[WORD_W-1-g*OP_W -: OP_W];
  end

  // narrow final slot: left-aligned, low bits padded with zero
  if (PAD_W > 0) begin : g_narrow
    assign ops[NSLOT-1] = {word[LAST_W-1:0], {PAD_W{1'b0}}};
  end else begin : g_wide
    assign ops[NSLOT-1] = word[OP_W-1:0];
  end

  assign op = ops[slot];
endmodule

// File: rtl/pkseq_loop_ctr.sv
module pkseq_loop_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             nz
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign nz = |cnt_q;
endmodule

// File: rtl/pkseq_word_hold.sv
module pkseq_word_hold #(
  parameter int WORD_W = 18,
  parameter int NSLOT  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [WORD_W-1:0]          in_word,
  input  logic                       drop,
  input  logic                       rewind,
  input  logic                       step,
  output logic                       have,
  output logic [WORD_W-1:0]          word_q,
  output logic [$clog2(NSLOT)-1:0]   slot_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      have   <= 1'b0;
      word_q <= '0;
      slot_q <= '0;
    end else if (!have) begin
      if (in_valid) begin
        have   <= 1'b1;
        word_q <= in_word;
        slot_q <= '0;
      end
    end else if (drop) begin
      have   <= 1'b0;
      slot_q <= '0;
    end else if (rewind) begin
      slot_q <= '0;
    end else if (step) begin
      slot_q <= slot_q + 1'b1;
    end
  end
endmodule

// File: rtl/pkseq_issue.sv
module pkseq_issue
  import pkseq_pkg::*;
#(
  parameter int              WORD_W    = 18,
  parameter int              OP_W      = OPW,
  parameter int              NSLOT     = 4,
  parameter int              CNT_W     = 8,
  parameter logic [OP_W-1:0] NOP_CODE  = OPC_NOP,
  parameter logic [OP_W-1:0] NEXT_CODE = OPC_NEXT
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [WORD_W-1:0]          in_word,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [OP_W-1:0]            out_op,
  output logic [$clog2(NSLOT)-1:0]   out_slot,
  input  logic                       cnt_load,
  input  logic [CNT_W-1:0]           cnt_value
);
  localparam int                SLOT_W    = $clog2(NSLOT);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT-1);

  logic              have;
  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;
  logic [OP_W-1:0]   cur_op;
  logic              cnt_nz;
  logic              is_nop, fire, rewind, advance, at_last, drop, step;

  pkseq_slot_mux #(.WORD_W(WORD_W), .OP_W(OP_W), .NSLOT(NSLOT)) u_mux (
    .word (word_q),
    .slot (slot_q),
    .op   (cur_op)
  );

  pkseq_loop_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_value),
    .dec      (rewind),
    .nz       (cnt_nz)
  );

  pkseq_word_hold #(.WORD_W(WORD_W), .NSLOT(NSLOT)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_word  (in_word),
    .drop     (drop),
    .rewind   (rewind),
    .step     (step),
    .have     (have),
    .word_q   (word_q),
    .slot_q   (slot_q)
  );

  always_comb begin
    is_nop  = have && (cur_op == NOP_CODE);
    fire    = have && !is_nop && out_ready;
    rewind  = fire && (cur_op == NEXT_CODE) && cnt_nz;
    advance = fire && !rewind;
    at_last = (slot_q == LAST_SLOT);
    drop    = is_nop || (advance && at_last);
    step    = advance && !at_last;
  end

  assign in_ready  = !have;
  assign out_valid = have && !is_nop;
  assign out_op    = cur_op;
  assign out_slot  = slot_q;
endmodule

// File: rtl/pkseq_issue_chk.sv
module pkseq_issue_chk #(
  parameter int              OP_W      = 5,
  parameter int              NSLOT     = 4,
  parameter logic [OP_W-1:0] NEXT_CODE = 5'b00100
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [OP_W-1:0]            out_op,
  input logic [$clog2(NSLOT)-1:0]   out_slot,
  input logic                       cnt_nz
);
  localparam int                SLOT_W    = $clog2(NSLOT);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT-1);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid)); // R1

  AST_ACCEPT_SLOT0: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_ready && out_slot == '0)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_slot))); // R4

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_slot != LAST_SLOT && !(out_op == NEXT_CODE && cnt_nz))
    |=> (!in_ready && out_slot == SLOT_W'($past(out_slot) + 1'b1))); // R4

  AST_WORD_END: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_slot == LAST_SLOT && !(out_op == NEXT_CODE && cnt_nz))
    |=> (in_ready && !out_valid)); // R5

  AST_NOP_REFETCH: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !in_ready) |=> in_ready); // R6

  AST_LOOP_BACK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_op == NEXT_CODE && cnt_nz)
    |=> (!in_ready && out_slot == '0)); // R7
endmodule

bind pkseq_issue pkseq_issue_chk #(
  .OP_W(OP_W), .NSLOT(NSLOT), .NEXT_CODE(NEXT_CODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_op    (out_op),
  .out_slot  (out_slot),
  .cnt_nz    (cnt_nz)
);

// File: tb/pkseq_issue_test.sv
module pkseq_issue_test;
  localparam logic [4:0] NOP  = 5'b11100;
  localparam logic [4:0] NXT  = 5'b00100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [4:0]  out_op;
  logic [1:0]  out_slot;
  logic        cnt_load = 1'b0;
  logic [7:0]  cnt_value = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pkseq_issue uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_slot(out_slot), .cnt_load(cnt_load),
    .cnt_value(cnt_value)
  );

  function automatic logic [4:0] slot_op(logic [17:0] w, logic [1:0] s);
    case (s)
      2'd0:    return w[17:13];
      2'd1:    return w[12:8];
      2'd2:    return w[7:3];
      default: return {w[2:0], 2'b00};
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // reference model, built from the requirements
  bit          m_have = 1'b0;
  logic [17:0] m_word = '0;
  logic [1:0]  m_slot = '0;
  logic [7:0]  m_cnt  = '0;
  logic [4:0]  m_op;
  bit          m_back;

  always @(posedge clk) begin
    if (rst) begin
      m_have = 1'b0; m_slot = '0; m_cnt = '0;
    end else begin
      m_op   = slot_op(m_word, m_slot);
      m_back = 1'b0;
      if (!m_have) begin
        if (in_valid) begin m_have = 1'b1; m_word = in_word; m_slot = '0; end
      end else if (m_op == NOP) begin
        m_have = 1'b0; m_slot = '0;
      end else if (out_ready) begin
        if (m_op == NXT && m_cnt != 0) begin m_back = 1'b1; m_slot = '0; end
        else if (m_slot == 2'd3) begin m_have = 1'b0; m_slot = '0; end
        else m_slot = m_slot + 1'b1;
      end
      if (cnt_load) m_cnt = cnt_value;
      else if (m_back) m_cnt = m_cnt - 1'b1;
    end
  end

  // lockstep comparison every cycle
  always @(negedge clk) begin
    if (!rst) begin
      bit ev;
      ev = m_have && (slot_op(m_word, m_slot) != NOP);
      chk("R4 model out_valid", out_valid, ev);
      chk("R2 model in_ready", in_ready, !m_have);
      if (ev) begin
        chk("R3 model out_op", out_op, slot_op(m_word, m_slot));
        chk("R4 model out_slot", out_slot, m_slot);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected<=%0d", cyc, 50000);
      finish_up();
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send(logic [17:0] w);
    in_valid = 1'b1; in_word = w;
    step();
    in_valid = 1'b0;
    chk("R2 in_ready after accept", in_ready, 0);
    chk("R2 slot0 presented", out_slot, 0);
  endtask

  task automatic take(string tag, int op, int slot);
    out_ready = 1'b1;
    chk(tag, out_valid, 1);
    chk(tag, out_op, op);
    chk(tag, out_slot, slot);
    step();
  endtask

  function automatic logic [4:0] pick_op();
    int k = $urandom_range(0, 15);
    if (k < 3) return NXT;
    if (k == 3) return NOP;
    return 5'($urandom);
  endfunction

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    chk("R1 in_ready after reset", in_ready, 1);
    chk("R1 out_valid after reset", out_valid, 0);

    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk("R10 idle out_valid", out_valid, 0);
      chk("R10 idle in_ready", in_ready, 1);
      step();
    end

    // counter is zero after reset: loop code in slot 3 falls through (R8, R1)
    send({5'd1, 5'd2, 5'd3, 3'b001});
    take("R3 slot0", 1, 0);
    take("R3 slot1", 2, 1);
    take("R3 slot2", 3, 2);
    take("R8 next at zero", 4, 3);
    chk("R8 word ends in_ready", in_ready, 1);
    chk("R5 out_valid after end", out_valid, 0);

    // stall holds (R4), narrow slot 3 (R3)
    send({5'd17, 5'd18, 5'd19, 3'b110});
    take("R4 first", 17, 0);
    out_ready = 1'b0;
    for (int i = 0; i < 2; i++) begin
      chk("R4 stall valid", out_valid, 1);
      chk("R4 stall op", out_op, 18);
      chk("R4 stall slot", out_slot, 1);
      step();
    end
    take("R4 after stall", 18, 1);
    take("R4 slot2", 19, 2);
    take("R3 narrow slot", 24, 3);
    chk("R5 in_ready after slot3", in_ready, 1);

    // no-op in middle, first and last slot (R6)
    send({5'd5, NOP, 5'd6, 3'b000});
    take("R6 before nop", 5, 0);
    chk("R6 nop not issued", out_valid, 0);
    chk("R6 no refetch yet", in_ready, 0);
    step();
    chk("R6 refetch after nop", in_ready, 1);
    send({NOP, 5'd1, 5'd1, 3'b000});
    chk("R6 nop slot0 not issued", out_valid, 0);
    step();
    chk("R6 refetch slot0 nop", in_ready, 1);
    send({5'd1, 5'd2, 5'd3, 3'b111});
    take("R6 a", 1, 0); take("R6 b", 2, 1); take("R6 c", 3, 2);
    chk("R6 nop slot3 not issued", out_valid, 0);
    step();
    chk("R6 refetch slot3 nop", in_ready, 1);

    // micro-loop: counter 2 gives three passes (R7, R9)
    cnt_load = 1'b1; cnt_value = 8'd2;
    step();
    cnt_load = 1'b0;
    send({5'd7, NXT, 5'd9, 3'b011});
    for (int p = 0; p < 3; p++) begin
      take("R7 loop body", 7, 0);
      chk("R7 no fetch in loop", in_ready, 0);
      take("R7 loop op", NXT, 1);
    end
    take("R7 fall through", 9, 2);
    take("R7 tail", 12, 3);
    chk("R7 word ends", in_ready, 1);

    // load at the same edge as a loop op: decision uses old value (R9)
    send({NXT, 5'd10, 5'd11, 3'b000});
    cnt_load = 1'b1; cnt_value = 8'd1;
    take("R9 next with load", NXT, 0);
    cnt_load = 1'b0;
    take("R9 old value decided", 10, 1);
    take("R9 c", 11, 2);
    take("R9 d", 0, 3);
    send({NXT, 5'd13, 5'd14, 3'b000});
    take("R9 loaded value used", NXT, 0);
    take("R9 loop back once", NXT, 0);
    take("R9 e", 13, 1);
    take("R9 f", 14, 2);
    take("R9 g", 0, 3);

    // constrained random, checked by the model
    for (int i = 0; i < 4000; i++) begin
      in_valid  = ($urandom_range(0, 9) < 7);
      in_word   = {pick_op(), pick_op(), pick_op(), 3'($urandom)};
      out_ready = ($urandom_range(0, 3) != 0);
      cnt_load  = ($urandom_range(0, 19) == 0);
      cnt_value = 8'($urandom_range(0, 3));
      step();
    end
    in_valid = 1'b0; cnt_load = 1'b0;
    finish_up();
  end
endmodule